// File: doc/BRIEF.md
# Dual-View DMA Channel Controller

This block is one DMA channel that software programs through a small register window. The same channel can be reached through two views. The compact view has a 16-bit count and a single offset that takes the command on a write and returns the status on a read. The full view has a 32-bit count and separate command and status offsets. Software loads a start address and a count equal to the number of transfers minus one, then writes a command word. The command word selects the unit size, the direction, a priority hint and the interrupt level, and it can set the start bit.

Once started, the channel waits for each device request. It then runs one handshake on the memory port and pulses the device acknowledge for a single cycle. After that it advances the address by the unit size and decrements the count. The run ends in one of three ways: the count passes below zero, the memory reports an error, or the start address does not suit the selected size. Each of these ends sets the pending-interrupt flag. The interrupt line follows that flag while interrupts are enabled. Reading the compact-view address clears the flag.

The memory port is valid/ready. `mem_valid` rises with address, direction, size, priority and write data. While `mem_ready` is low, all of these hold steady. The handshake completes on the first clock edge at which both are high, and `mem_err` is sampled on that edge. The device side uses a request/acknowledge pair. `dev_req` is sampled only while the channel waits for the next unit.

Top module: `dual_view_dma`

## Requirements
- R1: The count register holds transfers minus one. A count of 0 performs exactly one memory handshake, and a count of N performs N+1. On a normal end, the count reads back as all ones.
- R2: After each unit the address advances by 1 (byte), 2 (word, command bit 1) or 4 (longword, command bit 8). When bits 1 and 8 are both set, longword wins.
- R3: With command bit 2 clear, data moves from device to memory: `mem_we`=1 and `mem_wdata` is the `dev_din` value captured at the request. With bit 2 set, memory is read (`mem_we`=0) and `dev_dout` takes `mem_rdata`. `mem_prio` presents command bit 3.
- R4: Command bits 6:4 hold the interrupt level minus three, and `irq_level` outputs field+3. The pending flag (status bit 1) is set at every end of a run. `irq` is high only while the flag is set and command bit 0 (interrupt enable) is set.
- R5: The register offsets on `reg_addr` are as follows. The compact view has address at 0, count at 1 and command/status at 2. The full view has address at 4, count at 5, command at 6 and status at 7. A write to offset 2 loads the command and a read of offset 2 returns the status. A command written at offset 2 never selects longword: bit 8 is dropped.
- R6: A count written at offset 1 keeps only its low 16 bits, and offset 1 reads back the low 16 bits. A count written at offset 5 keeps all 32 bits.
- R7: Reading offset 0 returns the current address, clears the pending flag and drops `irq`.
- R8: If word size is selected with address bit 0 set, or longword size with address bits 1:0 nonzero, the start sets alignment error (status bit 5), halted (bit 3) and pending. No memory cycle is issued.
- R9: A memory handshake that completes with `mem_err` high sets bus error (status bit 4), halted and pending. The run stops without an acknowledge and without advancing the address.
- R10: Each unit waits for `dev_req`. `mem_valid` then stays high, with its address and direction stable, until `mem_ready`. `dev_ack` is high for exactly one cycle after each error-free handshake.
- R11: While a run is active, command, address and count writes are ignored. This includes a command with the start bit (bit 15).
- R12: Status bit 0 (armed) is high from an accepted start until the run ends. Bit 2 (active) is high during memory cycles. Bit 6 (count wrap) is set on a normal end. An accepted start clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect at offset 0) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| dev_req | input | 1 | Device requests one unit |
| dev_ack | output | 1 | One-cycle acknowledge per completed unit |
| dev_din | input | DW | Data from device |
| dev_dout | output | DW | Data to device |
| mem_valid | output | 1 | Memory cycle request |
| mem_ready | input | 1 | Memory accepts the cycle |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | 1 = memory write |
| mem_size | output | 2 | 0 byte, 1 word, 2 longword |
| mem_prio | output | 1 | Priority hint from the command |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_err | input | 1 | Error response, valid with mem_ready |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Interrupt level (field + 3) |

## Verification
Byte, word and longword runs are each started at a distinct address with a distinct count. The final address and the last memory address therefore separate the step sizes and expose any off-by-one in the N−1 count. One run sets both size bits, to confirm longword precedence. The same word command written through the compact view, with bit 8 set, confirms that bit 8 is masked there. Withheld `mem_ready` and withheld `dev_req` show the back-pressure and wait behaviour. An injected error on the third address and an odd word address separate the bus-error and alignment endings from a normal end. A start issued during a stalled run shows that the second command is ignored.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int REG_W  = 32;
  localparam int STAT_W = 7;

  localparam logic [2:0] OFS_LEG_ADDR = 3'd0;
  localparam logic [2:0] OFS_LEG_CNT  = 3'd1;
  localparam logic [2:0] OFS_LEG_CTL  = 3'd2;
  localparam logic [2:0] OFS_NAT_ADDR = 3'd4;
  localparam logic [2:0] OFS_NAT_CNT  = 3'd5;
  localparam logic [2:0] OFS_NAT_CMD  = 3'd6;
  localparam logic [2:0] OFS_NAT_STAT = 3'd7;

  localparam int CB_IEN   = 0;
  localparam int CB_WORD  = 1;
  localparam int CB_M2D   = 2;
  localparam int CB_PRIO  = 3;
  localparam int CB_LVL   = 4;
  localparam int CB_LWORD = 8;
  localparam int CB_GO    = 15;

  localparam int SB_ARMED = 0;
  localparam int SB_PEND  = 1;
  localparam int SB_ACC   = 2;
  localparam int SB_HALT  = 3;
  localparam int SB_BERR  = 4;
  localparam int SB_ALIGN = 5;
  localparam int SB_WRAP  = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MEM,
    ST_ACK
  } seq_state_e;

  typedef struct packed {
    logic       lword;
    logic [2:0] lvl;
    logic       prio;
    logic       m2d;
    logic       word;
    logic       ien;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [15:0] w, input logic native);
    cmd_t c;
    c.ien   = w[CB_IEN];
    c.word  = w[CB_WORD];
    c.m2d   = w[CB_M2D];
    c.prio  = w[CB_PRIO];
    c.lvl   = w[CB_LVL +: 3];
    c.lword = w[CB_LWORD] & native;
    return c;
  endfunction

  function automatic logic [15:0] cmd_encode(input cmd_t c);
    logic [15:0] r;
    r              = '0;
    r[CB_IEN]      = c.ien;
    r[CB_WORD]     = c.word;
    r[CB_M2D]      = c.m2d;
    r[CB_PRIO]     = c.prio;
    r[CB_LVL +: 3] = c.lvl;
    r[CB_LWORD]    = c.lword;
    return r;
  endfunction

  function automatic logic [1:0] size_code(input cmd_t c);
    if (c.lword)     return 2'd2;
    else if (c.word) return 2'd1;
    else             return 2'd0;
  endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_chan_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 32,
  parameter int LCW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic [AW-1:0]     addr_q,
  input  logic [CW-1:0]     count_q,
  input  logic [STAT_W-1:0] status,
  output cmd_t              cmd_q,
  output cmd_t              cmd_new,
  output logic              start_go,
  output logic              ld_addr,
  output logic              ld_cnt,
  output logic [AW-1:0]     addr_val,
  output logic [CW-1:0]     cnt_val,
  output logic              rd_clr
);

  logic is_nat_cmd;
  logic is_ctl;
  logic cmd_wr;
  logic unused_wbits;

  assign is_nat_cmd = (reg_addr == OFS_NAT_CMD);
  assign is_ctl     = (reg_addr == OFS_LEG_CTL) || is_nat_cmd;
  assign cmd_wr     = reg_wr && !busy && is_ctl;
  assign cmd_new    = cmd_decode(reg_wdata[15:0], is_nat_cmd);
  assign start_go   = cmd_wr && reg_wdata[CB_GO];

  assign ld_addr  = reg_wr && !busy &&
                    ((reg_addr == OFS_LEG_ADDR) || (reg_addr == OFS_NAT_ADDR));
  assign ld_cnt   = reg_wr && !busy &&
                    ((reg_addr == OFS_LEG_CNT) || (reg_addr == OFS_NAT_CNT));
  assign addr_val = reg_wdata[AW-1:0];
  assign cnt_val  = (reg_addr == OFS_LEG_CNT) ? CW'(reg_wdata[LCW-1:0])
                                              : reg_wdata[CW-1:0];
  assign rd_clr   = reg_rd && (reg_addr == OFS_LEG_ADDR);

  assign unused_wbits = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cmd_new;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_LEG_ADDR, OFS_NAT_ADDR: reg_rdata = REG_W'(addr_q);
      OFS_LEG_CNT:                reg_rdata = REG_W'(count_q[LCW-1:0]);
      OFS_NAT_CNT:                reg_rdata = REG_W'(count_q);
      OFS_LEG_CTL, OFS_NAT_STAT:  reg_rdata = REG_W'(status);
      OFS_NAT_CMD:                reg_rdata = REG_W'(cmd_encode(cmd_q));
      default:                    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  input  cmd_t          cmd_new,
  input  cmd_t          cmd_q,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic [AW-1:0] addr_val,
  input  logic [CW-1:0] cnt_val,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_din,
  output logic [DW-1:0] dev_dout,
  output logic          mem_valid,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] count_q,
  output logic          busy,
  output logic          in_mem,
  output logic          fl_halt,
  output logic          fl_berr,
  output logic          fl_align,
  output logic          fl_wrap,
  output logic          done_evt
);

  seq_state_e    state;
  logic [DW-1:0] wbuf_q;
  logic [DW-1:0] dout_q;
  logic [1:0]    new_size;
  logic          misalign;
  logic [2:0]    step;

  assign new_size = size_code(cmd_new);
  assign misalign = ((new_size == 2'd2) && (addr_q[1:0] != 2'b00)) ||
                    ((new_size == 2'd1) && addr_q[0]);

  always_comb begin
    unique case (size_code(cmd_q))
      2'd2:    step = 3'd4;
      2'd1:    step = 3'd2;
      default: step = 3'd1;
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign in_mem    = (state == ST_MEM);
  assign mem_valid = in_mem;
  assign mem_addr  = addr_q;
  assign mem_we    = !cmd_q.m2d;
  assign mem_size  = size_code(cmd_q);
  assign mem_wdata = wbuf_q;
  assign dev_dout  = dout_q;
  assign dev_ack   = (state == ST_ACK);

  assign done_evt = (start_go && !busy && misalign) ||
                    (in_mem && mem_ready && mem_err) ||
                    ((state == ST_ACK) && (count_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      count_q  <= '0;
      wbuf_q   <= '0;
      dout_q   <= '0;
      fl_halt  <= 1'b0;
      fl_berr  <= 1'b0;
      fl_align <= 1'b0;
      fl_wrap  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ld_addr) addr_q  <= addr_val;
          if (ld_cnt)  count_q <= cnt_val;
          if (start_go) begin
            fl_berr <= 1'b0;
            fl_wrap <= 1'b0;
            if (misalign) begin
              fl_align <= 1'b1;
              fl_halt  <= 1'b1;
            end else begin
              fl_align <= 1'b0;
              fl_halt  <= 1'b0;
              state    <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dev_req) begin
            wbuf_q <= dev_din;
            state  <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_ready) begin
            if (mem_err) begin
              fl_berr <= 1'b1;
              fl_halt <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              if (cmd_q.m2d) dout_q <= mem_rdata;
              state <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          addr_q  <= addr_q + AW'(step);
          count_q <= count_q - CW'(1);
          if (count_q == '0) begin
            fl_wrap <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_evt,
  input  logic       clr_evt,
  input  logic       ien,
  input  logic [2:0] lvl_field,
  output logic       pend,
  output logic       irq,
  output logic [2:0] irq_level
);

  localparam logic [2:0] LVL_BIAS = 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (clr_evt) pend <= 1'b0;
  end

  assign irq       = pend && ien;
  assign irq_level = lvl_field + LVL_BIAS;

endmodule

// File: rtl/dual_view_dma.sv
module dual_view_dma
  import dma_chan_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 32,
  parameter int LCW = 16,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_din,
  output logic [DW-1:0] dev_dout,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic          mem_prio,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          irq,
  output logic [2:0]    irq_level
);

  cmd_t              cmd_q;
  cmd_t              cmd_new;
  logic              start_go;
  logic              ld_addr;
  logic              ld_cnt;
  logic [AW-1:0]     addr_val;
  logic [CW-1:0]     cnt_val;
  logic              rd_clr;
  logic [AW-1:0]     addr_q;
  logic [CW-1:0]     count_q;
  logic              busy;
  logic              in_mem;
  logic              fl_halt;
  logic              fl_berr;
  logic              fl_align;
  logic              fl_wrap;
  logic              done_evt;
  logic              pend;
  logic [STAT_W-1:0] status;

  always_comb begin
    status           = '0;
    status[SB_ARMED] = busy;
    status[SB_PEND]  = pend;
    status[SB_ACC]   = in_mem;
    status[SB_HALT]  = fl_halt;
    status[SB_BERR]  = fl_berr;
    status[SB_ALIGN] = fl_align;
    status[SB_WRAP]  = fl_wrap;
  end

  assign mem_prio = cmd_q.prio;

  dma_reg_decode #(.AW(AW), .CW(CW), .LCW(LCW)) i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .addr_q   (addr_q),
    .count_q  (count_q),
    .status   (status),
    .cmd_q    (cmd_q),
    .cmd_new  (cmd_new),
    .start_go (start_go),
    .ld_addr  (ld_addr),
    .ld_cnt   (ld_cnt),
    .addr_val (addr_val),
    .cnt_val  (cnt_val),
    .rd_clr   (rd_clr)
  );

  dma_xfer_seq #(.AW(AW), .CW(CW), .DW(DW)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_go (start_go),
    .cmd_new  (cmd_new),
    .cmd_q    (cmd_q),
    .ld_addr  (ld_addr),
    .ld_cnt   (ld_cnt),
    .addr_val (addr_val),
    .cnt_val  (cnt_val),
    .dev_req  (dev_req),
    .dev_ack  (dev_ack),
    .dev_din  (dev_din),
    .dev_dout (dev_dout),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_err  (mem_err),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_size (mem_size),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .addr_q   (addr_q),
    .count_q  (count_q),
    .busy     (busy),
    .in_mem   (in_mem),
    .fl_halt  (fl_halt),
    .fl_berr  (fl_berr),
    .fl_align (fl_align),
    .fl_wrap  (fl_wrap),
    .done_evt (done_evt)
  );

  dma_irq_ctrl i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (done_evt),
    .clr_evt  (rd_clr || start_go),
    .ien      (cmd_q.ien),
    .lvl_field(cmd_q.lvl),
    .pend     (pend),
    .irq      (irq),
    .irq_level(irq_level)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          dev_ack,
  input logic          irq,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [6:0]    status
);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> !dev_ack);

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (reg_addr == 3'd0) && !status[0]) |=> !irq);

  // R4
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[1]);

  // R12
  acc_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (status[2] && status[0]));

  // R8
  align_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> (!mem_valid && !status[0] && status[3]));

endmodule

bind dual_view_dma dma_chan_chk #(.AW(AW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .dev_ack  (dev_ack),
  .irq      (irq),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .status   (status)
);

// File: tb/test_dual_view_dma.sv
`timescale 1ns/1ps
module test_dual_view_dma;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          dev_req = 1'b0, dev_ack;
  logic [DW-1:0] dev_din = 32'hCAFE0001, dev_dout;
  logic          mem_valid, mem_ready, mem_we, mem_prio, mem_err;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          irq;
  logic [2:0]    irq_level;

  logic          rdy_en = 1'b1, err_en = 1'b0;
  logic [AW-1:0] err_addr = '0;

  int n_chk = 0, n_bad = 0;
  int n_mem = 0, n_ack = 0;
  logic [AW-1:0] last_addr;
  logic          last_we, last_prio;
  logic [DW-1:0] last_wdata;
  bit            finished = 0;

  always #10 clk = ~clk;

  assign mem_ready = mem_valid & rdy_en;
  assign mem_err   = mem_valid & err_en & (mem_addr == err_addr);
  assign mem_rdata = ~mem_addr;

  dual_view_dma i_dual_view_dma (.*);

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      n_mem++;
      last_addr  = mem_addr;
      last_we    = mem_we;
      last_prio  = mem_prio;
      last_wdata = mem_wdata;
    end
    if (dev_ack) n_ack++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd(3'd7, s);
      if (!s[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(3'd7, s);
    chk("R12 reset status", s, 32'h0);
    chk("R4 reset irq", {31'b0, irq}, 32'h0);
    chk("R10 reset mem_valid", {31'b0, mem_valid}, 32'h0);
  endtask

  task automatic t_byte_run();
    logic [31:0] s;
    int m0 = n_mem, a0 = n_ack;
    wr(3'd4, 32'h100); wr(3'd5, 32'd3); dev_req = 1'b1;
    wr(3'd6, 32'h8021);
    wait_done();
    chk("R1 four handshakes", n_mem - m0, 4);
    chk("R10 four acks", n_ack - a0, 4);
    chk("R2 byte last addr", last_addr, 32'h103);
    chk("R3 dev->mem we", {31'b0, last_we}, 32'h1);
    chk("R3 write data", last_wdata, 32'hCAFE0001);
    chk("R4 irq raised", {31'b0, irq}, 32'h1);
    chk("R4 level field+3", {29'b0, irq_level}, 32'd5);
    rd(3'd7, s); chk("R12 end status", s, 32'h42);
    rd(3'd5, s); chk("R1 count wraps", s, 32'hFFFF_FFFF);
    rd(3'd4, s); chk("R2 byte final addr", s, 32'h104);
  endtask

  task automatic t_word_run();
    logic [31:0] s;
    int m0 = n_mem;
    wr(3'd4, 32'h200); wr(3'd5, 32'd2);
    wr(3'd6, 32'h8003);
    wait_done();
    chk("R1 three handshakes", n_mem - m0, 3);
    chk("R2 word last addr", last_addr, 32'h204);
    rd(3'd4, s); chk("R2 word final addr", s, 32'h206);
  endtask

  task automatic t_long_read();
    logic [31:0] s;
    wr(3'd4, 32'h300); wr(3'd5, 32'd1);
    wr(3'd6, 32'h810F);
    wait_done();
    chk("R2 longword wins last addr", last_addr, 32'h304);
    rd(3'd4, s); chk("R2 longword final addr", s, 32'h308);
    chk("R3 mem->dev we", {31'b0, last_we}, 32'h0);
    chk("R3 dev_dout", dev_dout, ~32'h304);
    chk("R3 prio", {31'b0, last_prio}, 32'h1);
  endtask

  task automatic t_legacy();
    logic [31:0] s;
    int m0 = n_mem;
    wr(3'd1, 32'h0001_0002);
    rd(3'd1, s); chk("R6 compact count low16", s, 32'h2);
    rd(3'd5, s); chk("R6 full count view", s, 32'h2);
    wr(3'd0, 32'h400);
    wr(3'd2, 32'h8103);
    wait_done();
    chk("R5 bit8 dropped, word step", last_addr, 32'h404);
    chk("R1 legacy three", n_mem - m0, 3);
    rd(3'd2, s); chk("R5 offset2 reads status", s, 32'h42);
    chk("R7 irq before clear", {31'b0, irq}, 32'h1);
    rd(3'd0, s); chk("R7 addr read value", s, 32'h406);
    @(negedge clk);
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);
    rd(3'd7, s); chk("R7 pending cleared", s, 32'h40);
    wr(3'd5, 32'h0001_0002);
    rd(3'd5, s); chk("R6 full count 32 bits", s, 32'h0001_0002);
  endtask

  task automatic t_misalign();
    logic [31:0] s;
    int m0 = n_mem;
    wr(3'd4, 32'h501); wr(3'd5, 32'd0);
    wr(3'd6, 32'h8003);
    rd(3'd7, s); chk("R8 align status", s, 32'h2A);
    repeat (4) @(negedge clk);
    chk("R8 no memory cycle", n_mem - m0, 0);
  endtask

  task automatic t_berr();
    logic [31:0] s;
    int m0 = n_mem, a0 = n_ack;
    err_addr = 32'h602; err_en = 1'b1;
    wr(3'd4, 32'h600); wr(3'd5, 32'd5);
    wr(3'd6, 32'h8001);
    wait_done();
    err_en = 1'b0;
    chk("R9 handshakes until error", n_mem - m0, 3);
    chk("R9 no ack on error", n_ack - a0, 2);
    rd(3'd7, s); chk("R9 berr status", s, 32'h1A);
    rd(3'd4, s); chk("R9 addr not advanced", s, 32'h602);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] s;
    int m0 = n_mem;
    dev_req = 1'b0;
    wr(3'd4, 32'h700); wr(3'd5, 32'd1);
    wr(3'd6, 32'h8001);
    repeat (5) @(negedge clk);
    rd(3'd7, s); chk("R12 armed while waiting", s, 32'h1);
    chk("R10 waits for request", n_mem - m0, 0);
    wr(3'd6, 32'h8102);
    wr(3'd4, 32'h900);
    rd(3'd6, s); chk("R11 cmd unchanged", s, 32'h1);
    dev_req = 1'b1;
    wait_done();
    rd(3'd4, s); chk("R11 byte steps kept", s, 32'h702);
    chk("R11 last addr", last_addr, 32'h701);
  endtask

  task automatic t_backpressure();
    logic [31:0] s;
    int m0 = n_mem, a0 = n_ack;
    rdy_en = 1'b0;
    wr(3'd4, 32'hA00); wr(3'd5, 32'd0);
    wr(3'd6, 32'h8000);
    repeat (6) @(negedge clk);
    chk("R10 valid held", {31'b0, mem_valid}, 32'h1);
    chk("R10 addr held", mem_addr, 32'hA00);
    chk("R10 no handshake yet", n_mem - m0, 0);
    rdy_en = 1'b1;
    wait_done();
    chk("R1 count zero one handshake", n_mem - m0, 1);
    chk("R10 one ack", n_ack - a0, 1);
    chk("R4 irq gated by enable", {31'b0, irq}, 32'h0);
    rd(3'd7, s); chk("R4 pending without enable", s, 32'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte_run();
    t_word_run();
    t_long_read();
    t_legacy();
    t_misalign();
    t_berr();
    t_busy_ignore();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule